// File: doc/BRIEF.md
# AES-128 Iterative Decryption Engine

This block recovers one 128-bit plaintext block from one 128-bit ciphertext block under a 128-bit cipher key, in electronic-codebook fashion. It processes one inverse round per clock, so a block goes through the single round datapath ten times.

Use has two phases. First a key is handed in. The engine spends ten cycles running the forward key expansion and keeps the last round key. Each ciphertext handed in afterwards is whitened with that last round key. The engine then walks the key schedule backwards one step per cycle while it applies the inverse rounds. The loaded key serves every later block until a new key replaces it. Both phases report through a busy level and a one-cycle finish pulse. A caller that starts the next block on the cycle after the finish pulse gets one result every eleven cycles.

Top module: `aes128_inv_core`

## Requirements
- R1: A key load accepted while the engine is idle raises `key_busy` on the next cycle. `key_busy` stays high for exactly 10 cycles, and `key_done` is high only on the last of them.
- R2: A ciphertext accepted while the engine is idle raises `ct_busy` on the next cycle. `ct_busy` stays high for exactly 10 cycles, and `ct_done` is high only on the last of them.
- R3: `pt_valid` is high for exactly one cycle, the cycle after `ct_done`. `pt_out` changes only on entry to that cycle and otherwise holds its value.
- R4: The result is the standard AES-128 inverse cipher. Ciphertext 69C4E0D86A7B0430D8CDB78070B4C55A under key 000102030405060708090A0B0C0D0E0F gives 00112233445566778899AABBCCDDEEFF. Byte 0 of every word is bits [127:120].
- R5: `key_load` and `ct_valid` have no effect while `key_busy` or `ct_busy` is high. They start nothing and produce no plaintext.
- R6: A loaded key stays in force for any number of later blocks, including blocks after an ignored key load.
- R7: A ciphertext presented on the cycle after `ct_done` is accepted. Its plaintext appears 11 cycles after the previous one.
- R8: When `key_load` and `ct_valid` are both high on an idle cycle, the key load is taken and the ciphertext is dropped.
- R9: During and after reset, all busy, finish and valid outputs are low and `pt_out` is zero.
- R10: Loading a new key makes every later block use the new key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_load | input | 1 | Request to take `key_in` as the new cipher key |
| key_in | input | 128 | Cipher key, sampled with `key_load` |
| key_busy | output | 1 | Key expansion in progress |
| key_done | output | 1 | Last cycle of key expansion |
| ct_valid | input | 1 | Request to decrypt `ct_in` |
| ct_in | input | 128 | Ciphertext block, sampled with `ct_valid` |
| ct_busy | output | 1 | Inverse rounds in progress |
| ct_done | output | 1 | Last inverse round cycle |
| pt_valid | output | 1 | `pt_out` carries a fresh plaintext this cycle |
| pt_out | output | 128 | Recovered plaintext, held until the next result |

## Verification
The bound checker watches the handshake on every cycle. It covers busy rising after an idle accept, the ten-cycle length of both busy phases (counted in the checker), finish landing on the last busy cycle, the plaintext pulse following finish, the output word holding between results, the two busy flags never being high together, and key priority on simultaneous requests. Whether the numbers are correct can only be shown by the bench's scenarios. These are published cipher vectors under several keys, blocks run back to back, key loads poked into a busy decryption, ciphertexts poked into a busy key expansion, and a key switch followed by a switch back.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

   localparam int unsigned BLK_W  = 128;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned NBYTES = BLK_W / 8;

   typedef logic [7:0]        byte_t;
   typedef logic [WORD_W-1:0] word_t;
   typedef logic [BLK_W-1:0]  blk_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_KEY  = 2'd1,
      ST_DEC  = 2'd2
   } ctl_st_e;

   // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic byte_t xt(input byte_t a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic byte_t gmul(input byte_t a, input byte_t b);
      byte_t p;
      byte_t x;
      p = 8'h00;
      x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p = p ^ x;
         x = xt(x);
      end
      return p;
   endfunction

   // a^254 is the multiplicative inverse; zero maps to zero
   function automatic byte_t gf_inv(input byte_t a);
      byte_t res;
      byte_t base;
      logic [7:0] e;
      res  = 8'h01;
      base = a;
      e    = 8'd254;
      for (int i = 0; i < 8; i++) begin
         if (e[i]) res = gmul(res, base);
         base = gmul(base, base);
      end
      return res;
   endfunction

   function automatic byte_t rotl8(input byte_t b, input int unsigned n);
      logic [15:0] d;
      d = {b, b} << n;
      return d[15:8];
   endfunction

   function automatic byte_t sbox(input byte_t a);
      byte_t q;
      q = gf_inv(a);
      return q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
   endfunction

   function automatic byte_t inv_sbox(input byte_t y);
      return gf_inv(rotl8(y, 1) ^ rotl8(y, 3) ^ rotl8(y, 6) ^ 8'h05);
   endfunction

   // round constant for expansion step idx (1-based)
   function automatic byte_t rcon(input int unsigned idx);
      byte_t r;
      r = 8'h01;
      for (int unsigned j = 1; j < 16; j++) begin
         if (j < idx) r = xt(r);
      end
      return r;
   endfunction

   function automatic word_t rot_sub(input word_t w);
      word_t t;
      t = {w[23:0], w[31:24]};
      return {sbox(t[31:24]), sbox(t[23:16]), sbox(t[15:8]), sbox(t[7:0])};
   endfunction

endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
   import aes_inv_pkg::*;
#(
   parameter bit INVERSE = 1'b0
) (
   input  blk_t  key_in,
   input  byte_t rc,
   output blk_t  key_out
);

   word_t w0, w1, w2, w3;
   assign {w0, w1, w2, w3} = key_in;

   generate
      if (INVERSE == 1'b0) begin : g_fwd
         word_t t, n0, n1, n2, n3;
         assign t  = rot_sub(w3) ^ {rc, 24'h000000};
         assign n0 = w0 ^ t;
         assign n1 = w1 ^ n0;
         assign n2 = w2 ^ n1;
         assign n3 = w3 ^ n2;
         assign key_out = {n0, n1, n2, n3};
      end else begin : g_rev
         word_t p0, p1, p2, p3;
         assign p3 = w3 ^ w2;
         assign p2 = w2 ^ w1;
         assign p1 = w1 ^ w0;
         assign p0 = w0 ^ rot_sub(p3) ^ {rc, 24'h000000};
         assign key_out = {p0, p1, p2, p3};
      end
   endgenerate

endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
   import aes_inv_pkg::*;
(
   input  blk_t blk_in,
   input  blk_t rkey,
   input  logic last,
   output blk_t blk_out
);

   byte_t ark [NBYTES];
   byte_t mix [NBYTES];

   generate
      for (genvar c = 0; c < 4; c++) begin : g_col
         for (genvar r = 0; r < 4; r++) begin : g_row
            // row r moves right by r columns when undoing the shift
            localparam int SRC = 4 * ((c - r + 4) % 4) + r;
            localparam int DST = 4 * c + r;
            assign ark[DST] = inv_sbox(blk_in[BLK_W-1-8*SRC -: 8])
                              ^ rkey[BLK_W-1-8*DST -: 8];
         end
         assign mix[4*c+0] = gmul(ark[4*c], 8'h0e) ^ gmul(ark[4*c+1], 8'h0b)
                           ^ gmul(ark[4*c+2], 8'h0d) ^ gmul(ark[4*c+3], 8'h09);
         assign mix[4*c+1] = gmul(ark[4*c], 8'h09) ^ gmul(ark[4*c+1], 8'h0e)
                           ^ gmul(ark[4*c+2], 8'h0b) ^ gmul(ark[4*c+3], 8'h0d);
         assign mix[4*c+2] = gmul(ark[4*c], 8'h0d) ^ gmul(ark[4*c+1], 8'h09)
                           ^ gmul(ark[4*c+2], 8'h0e) ^ gmul(ark[4*c+3], 8'h0b);
         assign mix[4*c+3] = gmul(ark[4*c], 8'h0b) ^ gmul(ark[4*c+1], 8'h0d)
                           ^ gmul(ark[4*c+2], 8'h09) ^ gmul(ark[4*c+3], 8'h0e);
      end
      for (genvar k = 0; k < NBYTES; k++) begin : g_out
         assign blk_out[BLK_W-1-8*k -: 8] = last ? ark[k] : mix[k];
      end
   endgenerate

endmodule

// File: rtl/aes_inv_ctrl.sv
module aes_inv_ctrl
   import aes_inv_pkg::*;
#(
   parameter int ROUNDS = 10,
   parameter int CNT_W  = $clog2(ROUNDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_load,
   input  logic             ct_valid,
   output logic [CNT_W-1:0] cnt,
   output logic             key_accept,
   output logic             ct_accept,
   output logic             key_busy,
   output logic             key_done,
   output logic             ct_busy,
   output logic             ct_done
);

   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ROUNDS);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   ctl_st_e st_q;
   logic    idle;

   assign idle       = (st_q == ST_IDLE);
   assign key_accept = idle && key_load;
   assign ct_accept  = idle && ct_valid && !key_load;
   assign key_busy   = (st_q == ST_KEY);
   assign ct_busy    = (st_q == ST_DEC);
   assign key_done   = key_busy && (cnt == CNT_TOP);
   assign ct_done    = ct_busy && (cnt == CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         cnt  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (key_accept) begin
                  st_q <= ST_KEY;
                  cnt  <= CNT_ONE;
               end else if (ct_accept) begin
                  st_q <= ST_DEC;
                  cnt  <= CNT_TOP;
               end
            end
            ST_KEY: begin
               if (key_done) begin
                  st_q <= ST_IDLE;
                  cnt  <= '0;
               end else begin
                  cnt <= cnt + CNT_ONE;
               end
            end
            ST_DEC: begin
               if (ct_done) begin
                  st_q <= ST_IDLE;
                  cnt  <= '0;
               end else begin
                  cnt <= cnt - CNT_ONE;
               end
            end
            default: begin
               st_q <= ST_IDLE;
               cnt  <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/aes128_inv_core.sv
module aes128_inv_core
   import aes_inv_pkg::*;
#(
   parameter int BLOCK_W         = 128,
   parameter int ROUNDS          = 10,
   parameter bit KEEP_CIPHER_KEY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               key_load,
   input  logic [BLOCK_W-1:0] key_in,
   output logic               key_busy,
   output logic               key_done,
   input  logic               ct_valid,
   input  logic [BLOCK_W-1:0] ct_in,
   output logic               ct_busy,
   output logic               ct_done,
   output logic               pt_valid,
   output logic [BLOCK_W-1:0] pt_out
);

   localparam int CNT_W = $clog2(ROUNDS + 1);

   generate
      if (BLOCK_W != 128) begin : g_bad_width
         $error("aes128_inv_core: BLOCK_W must be 128");
      end
      if (ROUNDS != 10) begin : g_bad_rounds
         $error("aes128_inv_core: ROUNDS must be 10 for a 128-bit key");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             key_accept, ct_accept;
   byte_t            rc_now;
   blk_t             last_rk_q, work_rk_q, state_q, pt_q;
   blk_t             fwd_rk, rev_rk, round_key, rnd_out;
   logic             pt_v_q;

   aes_inv_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .key_load   (key_load),
      .ct_valid   (ct_valid),
      .cnt        (cnt),
      .key_accept (key_accept),
      .ct_accept  (ct_accept),
      .key_busy   (key_busy),
      .key_done   (key_done),
      .ct_busy    (ct_busy),
      .ct_done    (ct_done)
   );

   // counter value doubles as the round-constant index in both phases
   assign rc_now = rcon(int'(cnt));

   aes_key_step #(.INVERSE(1'b0)) u_fwd (
      .key_in  (last_rk_q),
      .rc      (rc_now),
      .key_out (fwd_rk)
   );

   aes_key_step #(.INVERSE(1'b1)) u_rev (
      .key_in  (work_rk_q),
      .rc      (rc_now),
      .key_out (rev_rk)
   );

   generate
      if (KEEP_CIPHER_KEY) begin : g_keep_k0
         blk_t ck_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          ck_q <= '0;
            else if (key_accept) ck_q <= key_in;
         end
         // last inverse round takes the stored key instead of the derived one
         assign round_key = ct_done ? ck_q : rev_rk;
      end else begin : g_derive_k0
         assign round_key = rev_rk;
      end
   endgenerate

   aes_inv_round u_round (
      .blk_in  (state_q),
      .rkey    (round_key),
      .last    (ct_done),
      .blk_out (rnd_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_rk_q <= '0;
      end else if (key_accept) begin
         last_rk_q <= key_in;
      end else if (key_busy) begin
         last_rk_q <= fwd_rk;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= '0;
         work_rk_q <= '0;
      end else if (ct_accept) begin
         state_q   <= ct_in ^ last_rk_q;
         work_rk_q <= last_rk_q;
      end else if (ct_busy) begin
         state_q   <= rnd_out;
         work_rk_q <= round_key;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pt_v_q <= 1'b0;
         pt_q   <= '0;
      end else begin
         pt_v_q <= ct_done;
         if (ct_done) pt_q <= rnd_out;
      end
   end

   assign pt_valid = pt_v_q;
   assign pt_out   = pt_q;

endmodule

// File: rtl/aes128_inv_core_chk.sv
module aes128_inv_core_chk #(
   parameter int BLOCK_W = 128,
   parameter int ROUNDS  = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               key_load,
   input logic               key_busy,
   input logic               key_done,
   input logic               ct_valid,
   input logic               ct_busy,
   input logic               ct_done,
   input logic               pt_valid,
   input logic [BLOCK_W-1:0] pt_out
);

   logic [7:0] key_run, ct_run;
   logic       idle;

   assign idle = !key_busy && !ct_busy;

   // length of the current busy stretch, counted here rather than by $past depth
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_run <= '0;
         ct_run  <= '0;
      end else begin
         key_run <= key_busy ? key_run + 8'd1 : 8'd0;
         ct_run  <= ct_busy  ? ct_run  + 8'd1 : 8'd0;
      end
   end

   p_key_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (key_load && idle) |=> key_busy);
   p_key_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
      key_done |-> (key_busy && key_run == 8'(ROUNDS - 1)));
   p_key_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
      key_done |=> !key_busy);

   p_ct_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ct_valid && !key_load && idle) |=> ct_busy);
   p_ct_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ct_done |-> (ct_busy && ct_run == 8'(ROUNDS - 1)));

   p_pt_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ct_done |=> (pt_valid && !ct_busy));
   p_pt_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pt_valid |-> $past(ct_done));
   p_pt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !pt_valid |-> $stable(pt_out));

   p_busy_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({key_busy, ct_busy}));
   p_ct_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ct_busy && !ct_done) |=> (ct_busy && !key_busy));
   p_key_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (key_busy && !key_done) |=> (key_busy && !ct_busy));

   p_key_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (key_load && ct_valid && idle) |=> (key_busy && !ct_busy));

endmodule

bind aes128_inv_core aes128_inv_core_chk #(.BLOCK_W(BLOCK_W), .ROUNDS(ROUNDS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .key_load (key_load),
   .key_busy (key_busy),
   .key_done (key_done),
   .ct_valid (ct_valid),
   .ct_busy  (ct_busy),
   .ct_done  (ct_done),
   .pt_valid (pt_valid),
   .pt_out   (pt_out)
);

// File: tb/aes128_inv_core_tb.sv
module aes128_inv_core_tb;

   localparam time TCK = 4ns;

   localparam logic [127:0] KEY_A = 128'h000102030405060708090a0b0c0d0e0f;
   localparam logic [127:0] KEY_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;
   localparam logic [127:0] KEY_Z = 128'h0;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         key_load, ct_valid;
   logic [127:0] key_in, ct_in;
   logic         key_busy, key_done, ct_busy, ct_done, pt_valid;
   logic [127:0] pt_out;

   int           checks = 0;
   int           errors = 0;
   logic [127:0] exp_q[$];
   logic [127:0] exp_item;
   logic         done_d = 1'b0;

   always #(TCK/2) clk = ~clk;

   aes128_inv_core u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_load (key_load),
      .key_in   (key_in),
      .key_busy (key_busy),
      .key_done (key_done),
      .ct_valid (ct_valid),
      .ct_in    (ct_in),
      .ct_busy  (ct_busy),
      .ct_done  (ct_done),
      .pt_valid (pt_valid),
      .pt_out   (pt_out)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a plaintext appears
   always @(negedge clk) begin
      if (!rst_n) begin
         done_d = 1'b0;
      end else begin
         if (pt_valid) begin
            check(done_d, "R3", "plaintext not preceded by finish", 128'(done_d), 128'd1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R5", "plaintext with nothing pending", pt_out, 128'd0);
            end else begin
               exp_item = exp_q.pop_front();
               check(pt_out == exp_item, "R4", "plaintext value", pt_out, exp_item);
            end
         end
         done_d = ct_done;
      end
   end

   task automatic load_key(input logic [127:0] k, input bit poke_ct);
      int n;
      @(negedge clk);
      key_load = 1'b1;
      key_in   = k;
      @(negedge clk);
      key_load = 1'b0;
      check(key_busy == 1'b1, "R1", "key busy after accept", 128'(key_busy), 128'd1);
      n = 0;
      while (key_busy) begin
         n++;
         if (key_done) check(n == 10, "R1", "key finish cycle", 128'(n), 128'd10);
         if (poke_ct && n == 3) begin
            ct_valid = 1'b1;
            ct_in    = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
         end else begin
            ct_valid = 1'b0;
         end
         @(negedge clk);
      end
      ct_valid = 1'b0;
      check(n == 10, "R1", "key busy length", 128'(n), 128'd10);
      check(ct_busy == 1'b0, "R5", "cipher start during key busy", 128'(ct_busy), 128'd0);
   endtask

   task automatic decrypt(input logic [127:0] ct, input logic [127:0] pt,
                          input bit chained, input bit poke_key);
      int n;
      exp_q.push_back(pt);
      if (!chained) @(negedge clk);
      ct_valid = 1'b1;
      ct_in    = ct;
      @(negedge clk);
      ct_valid = 1'b0;
      n = 0;
      while (ct_busy) begin
         n++;
         if (ct_done) check(n == 10, "R2", "cipher finish cycle", 128'(n), 128'd10);
         if (poke_key && n == 4) begin
            key_load = 1'b1;
            key_in   = KEY_Z;
         end else begin
            key_load = 1'b0;
         end
         @(negedge clk);
      end
      key_load = 1'b0;
      check(n == 10, chained ? "R7" : "R2", "cipher busy length", 128'(n), 128'd10);
      check(key_busy == 1'b0, "R5", "key start during cipher busy", 128'(key_busy), 128'd0);
      check(pt_valid == 1'b1, "R3", "valid in cycle after finish", 128'(pt_valid), 128'd1);
   endtask

   initial begin
      rst_n    = 1'b0;
      key_load = 1'b0;
      ct_valid = 1'b0;
      key_in   = '0;
      ct_in    = '0;
      repeat (3) @(negedge clk);
      check({key_busy, key_done, ct_busy, ct_done, pt_valid} == 5'b0, "R9",
            "flags in reset", 128'({key_busy, key_done, ct_busy, ct_done, pt_valid}), 128'd0);
      check(pt_out == 128'd0, "R9", "output word in reset", pt_out, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check({key_busy, ct_busy, pt_valid} == 3'b0, "R9", "flags after reset",
            128'({key_busy, ct_busy, pt_valid}), 128'd0);

      // R1 key timing, R5 ciphertext poked during expansion
      load_key(KEY_A, 1'b1);
      // R4 reference vector
      decrypt(128'h69c4e0d86a7b0430d8cdb78070b4c55a,
              128'h00112233445566778899aabbccddeeff, 1'b0, 1'b0);

      // R10 new key; R5 key poked mid-block; R6 key still in force afterwards
      load_key(KEY_B, 1'b0);
      decrypt(128'h3925841d02dc09fbdc118597196a0b32,
              128'h3243f6a8885a308d313198a2e0370734, 1'b0, 1'b0);
      decrypt(128'h3ad77bb40d7a3660a89ecaf32466ef97,
              128'h6bc1bee22e409f96e93d7e117393172a, 1'b0, 1'b1);
      decrypt(128'hf5d3d58503b9699de785895a96fdbaaf,
              128'hae2d8a571e03ac9c9eb76fac45af8e51, 1'b0, 1'b0);

      // R7 back-to-back blocks
      decrypt(128'h3925841d02dc09fbdc118597196a0b32,
              128'h3243f6a8885a308d313198a2e0370734, 1'b0, 1'b0);
      decrypt(128'h3ad77bb40d7a3660a89ecaf32466ef97,
              128'h6bc1bee22e409f96e93d7e117393172a, 1'b1, 1'b0);
      decrypt(128'hf5d3d58503b9699de785895a96fdbaaf,
              128'hae2d8a571e03ac9c9eb76fac45af8e51, 1'b1, 1'b0);

      // R8 simultaneous requests: key wins, ciphertext dropped
      @(negedge clk);
      key_load = 1'b1;
      key_in   = KEY_Z;
      ct_valid = 1'b1;
      ct_in    = 128'h3925841d02dc09fbdc118597196a0b32;
      @(negedge clk);
      key_load = 1'b0;
      ct_valid = 1'b0;
      check(key_busy == 1'b1 && ct_busy == 1'b0, "R8", "key taken over cipher",
            128'({key_busy, ct_busy}), 128'b10);
      while (key_busy) @(negedge clk);
      decrypt(128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 128'h0, 1'b0, 1'b0);

      // R10 switch back to the first key
      load_key(KEY_A, 1'b0);
      decrypt(128'h69c4e0d86a7b0430d8cdb78070b4c55a,
              128'h00112233445566778899aabbccddeeff, 1'b0, 1'b0);

      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R4", "results still pending", 128'(exp_q.size()), 128'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule